// File: doc/BRIEF.md
# Multidrop UART Receiver with Majority Voting and Error Counters

This block is the receive half of an asynchronous serial port for multidrop links. A 16x oversampling enable drives it. It waits on an idle-high line for a falling edge. It checks that the start bit is real, then assembles a character of programmable shape. The character holds 7 or 8 data bits, least significant bit first. An address/data marker bit may follow the data, and a parity bit may follow that. The first stop bit closes the character. The receiver takes three samples of each bit around its centre and keeps the majority value. Any disagreement among the three samples marks the character as noisy.

When the first stop bit has been judged, the block updates a holding register and pulses a valid strobe for one clock. The register carries the data, the address/data marker, and flags for parity error, framing error, noise and break. Four saturating counters keep the number of characters that showed noise, framing errors, parity errors and breaks. A single strobe clears all four counters. A separate one-clock pulse reports an idle line: a full character time of continuous ones while the receiver is waiting for a start bit.

Top module: `mdrop_uart_rx`

## Requirements
- R1: While reset is asserted, and right after it, rx_valid, rx_idle, every flag, rx_data and all four counters read zero.
- R2: A frame is received as: a low start bit, the data bits least significant first, the optional marker bit, the optional parity bit, then the stop bit. Each bit lasts 16 enabled ticks. Every accepted character raises rx_valid for exactly one clock. rx_data is delivered on that pulse and held until the next character.
- R3: With cfg_len8=1 eight data bits are taken. With cfg_len8=0 seven are taken, and rx_data[7] is zero.
- R4: With cfg_addr_en=1 one marker bit follows the data and is reported on rx_addr. With cfg_addr_en=0 no marker bit is taken and rx_addr is zero.
- R5: cfg_par selects the parity check: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none (no parity bit is taken). The parity covers the data bits and the marker bit when it is present. rx_par_err is set when the received parity bit is wrong, and is never set with no parity.
- R6: Each bit is read at ticks 7, 8 and 9 of the bit, counting ticks from 0, and takes the majority value. A single flipped sample does not change the data. It does set rx_noise for that character, for any bit from the start bit through the stop bit.
- R7: A low level whose start-bit vote is high is discarded without a character, and the receiver goes back to hunting.
- R8: A stop bit that votes low sets rx_frame_err and still delivers the data. The receiver then waits for the line to go high before it hunts for a new start bit.
- R9: rx_break is set when all the data bits and the stop bit vote low. A break always also sets rx_frame_err.
- R10: rx_idle pulses once after 16 x (2 + data bits + marker bit + parity bit) ticks of a continuously high line while hunting. It pulses again only after the line has gone low.
- R11: cnt_noise, cnt_frame, cnt_parity and cnt_break each rise by one for every delivered character that carries the matching flag. Each stops at all ones.
- R12: A cnt_clr pulse sets all four counters to zero on the next clock, and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high, synchronised inside |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_addr_en | input | 1 | 1: marker bit follows the data |
| cfg_par | input | 2 | 01 even, 10 odd, 00/11 none |
| cnt_clr | input | 1 | Clears all error counters |
| rx_data | output | 8 | Received character |
| rx_addr | output | 1 | Received marker bit |
| rx_valid | output | 1 | One-clock strobe per character |
| rx_par_err | output | 1 | Parity error for this character |
| rx_frame_err | output | 1 | First stop bit voted low |
| rx_noise | output | 1 | Some bit had disagreeing samples |
| rx_break | output | 1 | Data and stop bit all low |
| rx_idle | output | 1 | One-clock idle-line pulse |
| cnt_noise | output | CNT_W | Noisy character count |
| cnt_frame | output | CNT_W | Framing error count |
| cnt_parity | output | CNT_W | Parity error count |
| cnt_break | output | CNT_W | Break count |

## Verification
The bench flips a single sample in the middle of a bit. If the design trusted one sample, the data comes out corrupted; if it did not compare the samples, the noise flag stays low. It sends a low pulse shorter than half a bit, which a design that trusts the edge would turn into a phantom character. It also holds the line low after a bad stop bit, which a design that hunts again at once would turn into an extra break. Back-to-back frames and long gaps check that idle fires only after a full character time and only once. A run of parity errors with narrow counters checks that a counter stops at all ones instead of wrapping.

// File: rtl/urx_pkg.sv
package urx_pkg;
   localparam int DW       = 8;
   localparam int MAX_BITS = 12;
   localparam int NCNT     = 4;
   localparam int CI_NOISE = 0;
   localparam int CI_FRAME = 1;
   localparam int CI_PAR   = 2;
   localparam int CI_BRK   = 3;

   localparam logic [1:0] PAR_EVEN = 2'b01;
   localparam logic [1:0] PAR_ODD  = 2'b10;

   typedef enum logic [2:0] {
      ST_HUNT, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP, ST_MARK
   } rx_state_e;

   typedef struct packed {
      logic [DW-1:0] data;
      logic          addr;
      logic          par_err;
      logic          frame_err;
      logic          noise;
      logic          brk;
   } rx_char_t;
endpackage

// File: rtl/urx_vote.sv
module urx_vote #(
   parameter int OVS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    rxd,
   input  logic [$clog2(OVS)-1:0]  phase,
   output logic                    line_s,
   output logic                    vote,
   output logic                    noisy
);
   localparam int PH_W = $clog2(OVS);
   localparam logic [PH_W-1:0] PH_A = PH_W'(OVS/2 - 1);
   localparam logic [PH_W-1:0] PH_B = PH_W'(OVS/2);

   logic meta_q, sync_q;
   logic smp_a, smp_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= 1'b1;
         sync_q <= 1'b1;
      end else begin
         meta_q <= rxd;
         sync_q <= meta_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_a <= 1'b1;
         smp_b <= 1'b1;
      end else if (tick) begin
         if (phase == PH_A) smp_a <= sync_q;
         if (phase == PH_B) smp_b <= sync_q;
      end
   end

   assign line_s = sync_q;
   assign vote   = (smp_a & smp_b) | (smp_a & sync_q) | (smp_b & sync_q);
   assign noisy  = (smp_a ^ smp_b) | (smp_b ^ sync_q);
endmodule

// File: rtl/urx_ctrl.sv
module urx_ctrl
   import urx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    line_s,
   input  logic                    vote,
   input  logic                    noisy,
   input  logic                    cfg_len8,
   input  logic                    cfg_addr_en,
   input  logic [1:0]              cfg_par,
   output logic [$clog2(OVS)-1:0]  phase,
   output logic                    hunting,
   output logic                    ch_valid,
   output rx_char_t                ch
);
   localparam int PH_W = $clog2(OVS);
   localparam logic [PH_W-1:0] PH_C    = PH_W'(OVS/2 + 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

   rx_state_e     state;
   logic [DW-1:0] shreg;
   logic [2:0]    bit_idx;
   logic          addr_q, par_q, noise_acc;

   logic          par_on;
   logic [2:0]    last_idx;
   logic [DW-1:0] data_now;
   logic          par_sum, par_err_now;
   rx_state_e     after_data, after_addr;

   always_comb begin
      par_on      = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
      last_idx    = cfg_len8 ? 3'd7 : 3'd6;
      data_now    = cfg_len8 ? shreg : {1'b0, shreg[DW-1:1]};
      par_sum     = (^data_now) ^ (cfg_addr_en & addr_q) ^ par_q;
      par_err_now = (cfg_par == PAR_EVEN) ? par_sum :
                    (cfg_par == PAR_ODD)  ? ~par_sum : 1'b0;
      after_addr  = par_on ? ST_PAR : ST_STOP;
      after_data  = cfg_addr_en ? ST_ADDR : after_addr;
   end

   assign hunting = (state == ST_HUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         phase     <= '0;
         shreg     <= '0;
         bit_idx   <= '0;
         addr_q    <= 1'b0;
         par_q     <= 1'b0;
         noise_acc <= 1'b0;
         ch_valid  <= 1'b0;
         ch        <= '0;
      end else begin
         ch_valid <= 1'b0;
         if (tick) begin
            case (state)
               ST_HUNT: begin
                  if (!line_s) begin
                     state     <= ST_START;
                     phase     <= PH_W'(1);
                     noise_acc <= 1'b0;
                  end
               end
               ST_MARK: begin
                  if (line_s) state <= ST_HUNT;
               end
               default: begin
                  phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                  if (phase == PH_C) begin
                     case (state)
                        ST_START: begin
                           if (vote) state <= ST_HUNT;
                           else      noise_acc <= noisy;
                        end
                        ST_DATA: begin
                           shreg     <= {vote, shreg[DW-1:1]};
                           noise_acc <= noise_acc | noisy;
                        end
                        ST_ADDR: begin
                           addr_q    <= vote;
                           noise_acc <= noise_acc | noisy;
                        end
                        ST_PAR: begin
                           par_q     <= vote;
                           noise_acc <= noise_acc | noisy;
                        end
                        ST_STOP: begin
                           ch.data      <= data_now;
                           ch.addr      <= cfg_addr_en & addr_q;
                           ch.par_err   <= par_err_now;
                           ch.frame_err <= ~vote;
                           ch.noise     <= noise_acc | noisy;
                           ch.brk       <= ~vote && (data_now == '0);
                           ch_valid     <= 1'b1;
                           state        <= vote ? ST_HUNT : ST_MARK;
                        end
                        default: ;
                     endcase
                  end
                  if (phase == PH_LAST) begin
                     case (state)
                        ST_START: begin
                           state   <= ST_DATA;
                           bit_idx <= '0;
                        end
                        ST_DATA: begin
                           if (bit_idx == last_idx) state <= after_data;
                           else bit_idx <= bit_idx + 1'b1;
                        end
                        ST_ADDR: state <= after_addr;
                        ST_PAR:  state <= ST_STOP;
                        default: ;
                     endcase
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/urx_idle.sv
module urx_idle #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         arm,
   input  logic [W-1:0] limit,
   output logic         pulse
);
   logic [W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (!arm) begin
            run_q <= '0;
         end else if (tick && run_q != limit) begin
            run_q <= run_q + 1'b1;
            if (run_q == limit - 1'b1) pulse <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/urx_sat_cnt.sv
module urx_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
   import urx_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             rxd,
   input  logic             cfg_len8,
   input  logic             cfg_addr_en,
   input  logic [1:0]       cfg_par,
   input  logic             cnt_clr,
   output logic [7:0]       rx_data,
   output logic             rx_addr,
   output logic             rx_valid,
   output logic             rx_par_err,
   output logic             rx_frame_err,
   output logic             rx_noise,
   output logic             rx_break,
   output logic             rx_idle,
   output logic [CNT_W-1:0] cnt_noise,
   output logic [CNT_W-1:0] cnt_frame,
   output logic [CNT_W-1:0] cnt_parity,
   output logic [CNT_W-1:0] cnt_break
);
   localparam int PH_W  = $clog2(OVS);
   localparam int IDL_W = $clog2(OVS * MAX_BITS + 1);

   if (OVS < 8 || OVS > 64) begin : g_bad_ovs
      $error("mdrop_uart_rx: OVS must lie in 8..64");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("mdrop_uart_rx: CNT_W must lie in 2..32");
   end

   logic            line_s, vote, noisy, hunting, ch_valid;
   logic [PH_W-1:0] phase;
   rx_char_t        ch;
   int              nbits;
   logic [IDL_W-1:0] idle_lim;
   logic [NCNT-1:0] inc;
   logic [CNT_W-1:0] cnt_q [NCNT];

   urx_vote #(.OVS(OVS)) u_vote (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .phase(phase),
      .line_s(line_s), .vote(vote), .noisy(noisy)
   );

   urx_ctrl #(.OVS(OVS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .line_s(line_s), .vote(vote),
      .noisy(noisy), .cfg_len8(cfg_len8), .cfg_addr_en(cfg_addr_en),
      .cfg_par(cfg_par), .phase(phase), .hunting(hunting),
      .ch_valid(ch_valid), .ch(ch)
   );

   always_comb begin
      nbits = 2 + (cfg_len8 ? 8 : 7) + (cfg_addr_en ? 1 : 0)
                + ((cfg_par == PAR_EVEN || cfg_par == PAR_ODD) ? 1 : 0);
      idle_lim = IDL_W'(OVS * nbits);
   end

   urx_idle #(.W(IDL_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .arm(hunting & line_s),
      .limit(idle_lim), .pulse(rx_idle)
   );

   always_comb begin
      inc[CI_NOISE] = ch_valid & ch.noise;
      inc[CI_FRAME] = ch_valid & ch.frame_err;
      inc[CI_PAR]   = ch_valid & ch.par_err;
      inc[CI_BRK]   = ch_valid & ch.brk;
   end

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      urx_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc[i]), .cnt(cnt_q[i])
      );
   end

   assign cnt_noise    = cnt_q[CI_NOISE];
   assign cnt_frame    = cnt_q[CI_FRAME];
   assign cnt_parity   = cnt_q[CI_PAR];
   assign cnt_break    = cnt_q[CI_BRK];
   assign rx_data      = ch.data;
   assign rx_addr      = ch.addr;
   assign rx_valid     = ch_valid;
   assign rx_par_err   = ch.par_err;
   assign rx_frame_err = ch.frame_err;
   assign rx_noise     = ch.noise;
   assign rx_break     = ch.brk;
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_len8,
   input logic             cfg_addr_en,
   input logic [1:0]       cfg_par,
   input logic             cnt_clr,
   input logic [7:0]       rx_data,
   input logic             rx_addr,
   input logic             rx_valid,
   input logic             rx_par_err,
   input logic             rx_frame_err,
   input logic             rx_break,
   input logic             rx_idle,
   input logic [CNT_W-1:0] cnt_noise,
   input logic [CNT_W-1:0] cnt_frame,
   input logic [CNT_W-1:0] cnt_parity,
   input logic [CNT_W-1:0] cnt_break
);
   AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R2
   AST_SEVEN_BIT_TOP: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !cfg_len8) |-> !rx_data[7]); // R3
   AST_MARKER_OFF: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !cfg_addr_en) |-> !rx_addr); // R4
   AST_NO_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !(cfg_par == 2'b01 || cfg_par == 2'b10)) |-> !rx_par_err); // R5
   AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && rx_break) |-> rx_frame_err); // R9
   AST_IDLE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(rx_valid && rx_idle)); // R10
   AST_STEP_NOISE: assert property (@(posedge clk) disable iff (!rst_n) !cnt_clr |=> (CNT_W'(cnt_noise - $past(cnt_noise)) <= 1)); // R11
   AST_STEP_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !cnt_clr |=> (CNT_W'(cnt_frame - $past(cnt_frame)) <= 1)); // R11
   AST_STEP_PARITY: assert property (@(posedge clk) disable iff (!rst_n) !cnt_clr |=> (CNT_W'(cnt_parity - $past(cnt_parity)) <= 1)); // R11
   AST_STEP_BREAK: assert property (@(posedge clk) disable iff (!rst_n) !cnt_clr |=> (CNT_W'(cnt_break - $past(cnt_break)) <= 1)); // R11
   AST_BREAK_COUNTED: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && rx_break && !cnt_clr && cnt_break != '1) |=> (cnt_break == $past(cnt_break) + 1'b1)); // R11
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> (cnt_noise == '0 && cnt_frame == '0 && cnt_parity == '0 && cnt_break == '0)); // R12
endmodule

bind mdrop_uart_rx urx_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_len8(cfg_len8), .cfg_addr_en(cfg_addr_en),
   .cfg_par(cfg_par), .cnt_clr(cnt_clr), .rx_data(rx_data), .rx_addr(rx_addr),
   .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err),
   .rx_break(rx_break), .rx_idle(rx_idle), .cnt_noise(cnt_noise),
   .cnt_frame(cnt_frame), .cnt_parity(cnt_parity), .cnt_break(cnt_break)
);

// File: tb/sim_mdrop_uart_rx.sv
module sim_mdrop_uart_rx;
   localparam int CW = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b1;
   logic rxd = 1'b1;
   logic cfg_len8 = 1'b1;
   logic cfg_addr_en = 1'b0;
   logic [1:0] cfg_par = 2'b00;
   logic cnt_clr = 1'b0;
   logic [7:0] rx_data;
   logic rx_addr, rx_valid, rx_par_err, rx_frame_err, rx_noise, rx_break, rx_idle;
   logic [CW-1:0] cnt_noise, cnt_frame, cnt_parity, cnt_break;

   int n_chk = 0;
   int n_err = 0;
   int n_valid = 0;
   int n_idle = 0;
   int e_noise = 0, e_frame = 0, e_par = 0, e_brk = 0;

   always #4 clk = ~clk;

   mdrop_uart_rx #(.OVS(16), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len8(cfg_len8),
      .cfg_addr_en(cfg_addr_en), .cfg_par(cfg_par), .cnt_clr(cnt_clr),
      .rx_data(rx_data), .rx_addr(rx_addr), .rx_valid(rx_valid),
      .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err), .rx_noise(rx_noise),
      .rx_break(rx_break), .rx_idle(rx_idle), .cnt_noise(cnt_noise),
      .cnt_frame(cnt_frame), .cnt_parity(cnt_parity), .cnt_break(cnt_break)
   );

   always @(negedge clk) begin
      if (rx_valid) n_valid++;
      if (rx_idle)  n_idle++;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   function automatic bit par_used();
      return (cfg_par == 2'b01) || (cfg_par == 2'b10);
   endfunction

   function automatic int frame_bits();
      return 2 + (cfg_len8 ? 8 : 7) + (cfg_addr_en ? 1 : 0) + (par_used() ? 1 : 0);
   endfunction

   task automatic check_counters(input string tag);
      chk(int'(cnt_noise) == e_noise, "R11", {tag, " noise count"}, int'(cnt_noise), e_noise);
      chk(int'(cnt_frame) == e_frame, "R11", {tag, " frame count"}, int'(cnt_frame), e_frame);
      chk(int'(cnt_parity) == e_par, "R11", {tag, " parity count"}, int'(cnt_parity), e_par);
      chk(int'(cnt_break) == e_brk, "R11", {tag, " break count"}, int'(cnt_break), e_brk);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic a, input bit par_bad,
                             input bit stop_v, input int glitch, input int gap);
      logic [11:0] bits;
      int nb;
      int v0;
      logic [7:0] dm;
      logic pb;
      bit e_pe, e_fe, e_nz, e_bk;
      dm = cfg_len8 ? d : {1'b0, d[6:0]};
      bits = '0;
      nb = 1;
      for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) begin
         bits[nb] = d[i];
         nb++;
      end
      if (cfg_addr_en) begin
         bits[nb] = a;
         nb++;
      end
      if (par_used()) begin
         pb = (^dm) ^ (cfg_addr_en & a);
         if (cfg_par == 2'b10) pb = ~pb;
         bits[nb] = pb ^ par_bad;
         nb++;
      end
      bits[nb] = stop_v;
      nb++;
      v0 = n_valid;
      for (int i = 0; i < nb; i++) begin
         for (int t = 0; t < 16; t++) begin
            rxd = (i == glitch && t == 8) ? ~bits[i] : bits[i];
            @(negedge clk);
         end
      end
      if (!stop_v) begin
         rxd = 1'b0;
         repeat (16) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (gap) @(negedge clk);
      e_pe = par_used() && par_bad;
      e_fe = !stop_v;
      e_nz = (glitch >= 0) && (glitch < nb);
      e_bk = (dm == 8'h00) && !stop_v;
      if (e_nz) e_noise = sat_inc(e_noise);
      if (e_fe) e_frame = sat_inc(e_frame);
      if (e_pe) e_par   = sat_inc(e_par);
      if (e_bk) e_brk   = sat_inc(e_brk);
      chk(n_valid == v0 + 1, "R2", "one valid pulse per frame", n_valid - v0, 1);
      chk(rx_data == dm, cfg_len8 ? "R2" : "R3", "data", int'(rx_data), int'(dm));
      chk(rx_addr == (cfg_addr_en & a), "R4", "marker bit", int'(rx_addr), int'(cfg_addr_en & a));
      chk(rx_par_err == e_pe, "R5", "parity flag", int'(rx_par_err), int'(e_pe));
      chk(rx_frame_err == e_fe, "R8", "framing flag", int'(rx_frame_err), int'(e_fe));
      chk(rx_noise == e_nz, "R6", "noise flag", int'(rx_noise), int'(e_nz));
      chk(rx_break == e_bk, "R9", "break flag", int'(rx_break), int'(e_bk));
      check_counters("frame");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int idle0;
      int v0;
      void'($urandom(32'h5eed_1234));
      repeat (6) @(negedge clk);
      // R1 reset state
      chk(rx_valid == 1'b0 && rx_idle == 1'b0, "R1", "strobes in reset", int'(rx_valid) + int'(rx_idle), 0);
      chk(rx_data == 8'h00 && {rx_addr, rx_par_err, rx_frame_err, rx_noise, rx_break} == '0, "R1", "holding register in reset", int'(rx_data), 0);
      check_counters("reset R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_valid == 1'b0 && rx_data == 8'h00, "R1", "after reset", int'(rx_data), 0);

      // R10 idle from reset, once only
      repeat (16 * 10 + 30) @(negedge clk);
      chk(n_idle == 1, "R10", "idle after a character time", n_idle, 1);
      repeat (400) @(negedge clk);
      chk(n_idle == 1, "R10", "idle fires once per idle period", n_idle, 1);

      // R2 plain 8-bit frame
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1, -1, 8);
      send_frame(8'h01, 1'b0, 1'b0, 1'b1, -1, 8);
      // R3 seven-bit frame
      cfg_len8 = 1'b0;
      send_frame(8'hD3, 1'b0, 1'b0, 1'b1, -1, 8);
      // R4 R5 marker bit with even parity, then odd parity good and bad
      cfg_len8 = 1'b1; cfg_addr_en = 1'b1; cfg_par = 2'b01;
      send_frame(8'h3E, 1'b1, 1'b0, 1'b1, -1, 8);
      cfg_par = 2'b10;
      send_frame(8'h81, 1'b1, 1'b0, 1'b1, -1, 8);
      send_frame(8'h81, 1'b0, 1'b1, 1'b1, -1, 8);
      cfg_addr_en = 1'b0; cfg_par = 2'b11;
      send_frame(8'h77, 1'b0, 1'b0, 1'b1, -1, 8);
      // R6 single disagreeing sample on a data bit, on start, on stop
      cfg_par = 2'b00;
      send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 4, 8);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 0, 8);
      send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 9, 8);
      // R7 short low pulse is not a start bit
      v0 = n_valid;
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (60) @(negedge clk);
      chk(n_valid == v0, "R7", "false start discarded", n_valid - v0, 0);
      // R8 framing error with long low tail, no extra character
      send_frame(8'h3C, 1'b0, 1'b0, 1'b0, -1, 300);
      // R9 break
      send_frame(8'h00, 1'b0, 1'b0, 1'b0, -1, 300);
      // R10 back-to-back frames give no idle, a long gap gives one
      idle0 = n_idle;
      send_frame(8'h11, 1'b0, 1'b0, 1'b1, -1, 0);
      send_frame(8'h22, 1'b0, 1'b0, 1'b1, -1, 0);
      send_frame(8'h33, 1'b0, 1'b0, 1'b1, -1, 2);
      chk(n_idle == idle0, "R10", "no idle between close frames", n_idle - idle0, 0);
      send_frame(8'h44, 1'b0, 1'b0, 1'b1, -1, frame_bits() * 16 + 20);
      chk(n_idle == idle0 + 1, "R10", "idle after long gap", n_idle - idle0, 1);

      // random mix of formats and faults
      for (int k = 0; k < 50; k++) begin
         logic [7:0] d;
         bit sv;
         int gl;
         cfg_len8 = 1'($urandom % 2);
         cfg_addr_en = 1'($urandom % 2);
         cfg_par = 2'($urandom % 4);
         d = 8'($urandom);
         sv = ($urandom % 8) != 0;
         if (!sv && ($urandom % 2) == 0) d = 8'h00;
         gl = (($urandom % 3) == 0) ? int'($urandom % frame_bits()) : -1;
         send_frame(d, 1'($urandom % 2), ($urandom % 4) == 0, sv, gl, 4 + int'($urandom % 30));
      end

      // R11 saturation of the parity counter
      cfg_len8 = 1'b1; cfg_addr_en = 1'b0; cfg_par = 2'b01;
      for (int k = 0; k < CMAX + 2; k++) begin
         send_frame(8'(k * 7 + 1), 1'b0, 1'b1, 1'b1, -1, 4);
      end
      chk(int'(cnt_parity) == CMAX, "R11", "parity counter holds at all ones", int'(cnt_parity), CMAX);

      // R12 clear
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      e_noise = 0; e_frame = 0; e_par = 0; e_brk = 0;
      chk(cnt_noise == '0 && cnt_frame == '0 && cnt_parity == '0 && cnt_break == '0, "R12", "counters cleared",
          int'(cnt_noise) + int'(cnt_frame) + int'(cnt_parity) + int'(cnt_break), 0);
      send_frame(8'h00, 1'b0, 1'b1, 1'b0, 2, 40);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule